// File: doc/BRIEF.md
# Serial EEPROM Write-Path Target

This block is the write side of a two-wire serial EEPROM target. It watches the bus clock and data lines, finds START and STOP conditions, and checks the 7-bit device address with the write direction bit. It then takes an 8-bit word address, which picks one of 256 byte cells. The data bytes that follow are collected in a 16-entry page buffer. Nothing reaches the storage array while bytes are still arriving. The array is updated only at the end of a timed internal program cycle, and that cycle starts when the host sends STOP.

While the program cycle runs, the `busy_o` status output is high and the target ignores all bus traffic. It does not even acknowledge its own address. A host can therefore poll with repeated START plus device address until it gets an acknowledge. A write-protect input guards the upper half of the array. For a protected target cell, the device and word address bytes are still acknowledged, but the first data byte is refused and no program cycle starts.

The clock and data lines are synchronised into the system clock domain. The acknowledge is driven as an open-drain pull-down enable. A side read port exposes the array contents for inspection, because the bus read path is not part of this block.

Top module: `eeprom_wr_target`

## Requirements
- R1: After reset, `busy_o` is low, `sda_oe_o` is low, and every array byte reads 0x00.
- R2: A byte whose upper 7 bits equal DEV_ADDR (default 0x50) and whose bit 0 is 0 (write) is acknowledged (SDA pulled low in the ninth clock). Any other device byte, including a read request (bit 0 = 1), gets no acknowledge.
- R3: Once the device byte is accepted, the word address byte and each data byte that follows are acknowledged.
- R4: Received data does not reach the array before STOP. After the program cycle that follows STOP, the array holds the received data at the addressed cells.
- R5: A STOP that ends a write with at least one accepted data byte raises `busy_o` for exactly WRITE_CYCLES consecutive clocks.
- R6: While `busy_o` is high, the target acknowledges nothing, and a complete write transaction sent in that time leaves the array unchanged.
- R7: After `busy_o` falls, a START followed by the write-mode device byte is acknowledged again.
- R8: Consecutive data bytes go to consecutive cells. Only the low 4 address bits advance and wrap from 0xF to 0x0, and the upper 4 bits stay fixed.
- R9: If more than 16 data bytes arrive before STOP, later bytes overwrite the earlier bytes at the same page offset, and the last value sent to each offset is the one programmed.
- R10: With `wp_i` high and word address bit 7 set, the device and word address bytes are acknowledged, the first data byte is not acknowledged, `busy_o` stays low after STOP, and the array is unchanged.
- R11: With `wp_i` high and word address bit 7 clear, the write proceeds normally.
- R12: A STOP after the word address byte but before any data byte starts no program cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Bus clock line level |
| sda_i | input | 1 | Bus data line level |
| wp_i | input | 1 | Write-protect for the upper half of the array |
| sda_oe_o | output | 1 | When high, the data line is pulled low (acknowledge) |
| busy_o | output | 1 | High while the internal program cycle runs |
| peek_addr_i | input | 8 | Inspection read address into the array |
| peek_data_o | output | 8 | Array byte at `peek_addr_i` |

## Verification
Some internal faults show up at once. A wrong page offset or a broken wrap shows as bytes at the wrong cells, and so does a protection check made at the wrong moment. A bad bit counter or address compare shows up in the ninth clock of the faulty byte, as a missing or extra pull-down on the data line. Other faults only show after the program cycle. A buffer-valid mask that is not cleared, or a program cycle of the wrong length, is visible only once `busy_o` falls. It appears as a busy pulse that is off by a clock count, or as stale cells in the array. A busy state that fails to hold the bus off shows up as an acknowledge during polling, inside the first byte sent after STOP.

// File: rtl/ee_wr_pkg.sv
package ee_wr_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_DEV,
        S_DEV_ACK,
        S_WADR,
        S_WADR_ACK,
        S_DATA,
        S_DATA_ACK
    } bus_st_e;

endpackage

// File: rtl/ee_line_sync.sv
module ee_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_lvl_o,
    output logic scl_rise_o,
    output logic scl_fall_o,
    output logic start_o,
    output logic stop_o
);

    typedef struct packed {
        logic [STAGES-1:0] scl_sh;
        logic [STAGES-1:0] sda_sh;
        logic              scl_p;
        logic              sda_p;
    } sync_s;

    sync_s q, n;

    logic scl_s, sda_s;
    assign scl_s = q.scl_sh[STAGES-1];
    assign sda_s = q.sda_sh[STAGES-1];

    always_comb begin
        n        = q;
        n.scl_sh = {q.scl_sh[STAGES-2:0], scl_i};
        n.sda_sh = {q.sda_sh[STAGES-2:0], sda_i};
        n.scl_p  = scl_s;
        n.sda_p  = sda_s;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '1;
        else        q <= n;
    end

    assign sda_lvl_o  = sda_s;
    assign scl_rise_o = scl_s & ~q.scl_p;
    assign scl_fall_o = ~scl_s & q.scl_p;
    assign start_o    = scl_s & q.scl_p & q.sda_p & ~sda_s;
    assign stop_o     = scl_s & q.scl_p & ~q.sda_p & sda_s;

endmodule

// File: rtl/ee_byte_fsm.sv
module ee_byte_fsm
    import ee_wr_pkg::*;
#(
    parameter logic [6:0] DEV_ADDR = 7'h50,
    parameter int         ADDR_W   = 8,
    parameter int         PAGE_W   = 4
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     scl_rise_i,
    input  logic                     scl_fall_i,
    input  logic                     start_i,
    input  logic                     stop_i,
    input  logic                     sda_lvl_i,
    input  logic                     wp_i,
    input  logic                     busy_i,
    output logic                     ack_oe_o,
    output logic                     txn_start_o,
    output logic                     buf_we_o,
    output logic [PAGE_W-1:0]        buf_idx_o,
    output logic [7:0]               buf_data_o,
    output logic                     commit_o,
    output logic [ADDR_W-PAGE_W-1:0] page_o
);

    localparam int                HI_W    = ADDR_W - PAGE_W;
    localparam logic [PAGE_W-1:0] PTR_ONE = PAGE_W'(1);

    typedef struct packed {
        bus_st_e           st;
        logic [3:0]        bitn;
        logic [7:0]        sh;
        logic [HI_W-1:0]   page;
        logic [PAGE_W-1:0] ptr;
        logic              have;
        logic              oe;
    } fsm_s;

    fsm_s q, n;
    logic we_d, commit_d, txn_d;

    always_comb begin
        n        = q;
        we_d     = 1'b0;
        commit_d = 1'b0;
        txn_d    = 1'b0;
        if (busy_i) begin
            n.st   = S_IDLE;
            n.oe   = 1'b0;
            n.have = 1'b0;
        end else if (start_i) begin
            n.st   = S_DEV;
            n.bitn = 4'd0;
            n.oe   = 1'b0;
            n.have = 1'b0;
            txn_d  = 1'b1;
        end else if (stop_i) begin
            if ((q.st == S_DATA || q.st == S_DATA_ACK) && q.have) commit_d = 1'b1;
            n.st   = S_IDLE;
            n.oe   = 1'b0;
            n.have = 1'b0;
        end else begin
            unique case (q.st)
                S_DEV, S_WADR, S_DATA: begin
                    if (scl_rise_i && q.bitn != 4'd8) begin
                        n.sh   = {q.sh[6:0], sda_lvl_i};
                        n.bitn = q.bitn + 4'd1;
                    end else if (scl_fall_i && q.bitn == 4'd8) begin
                        if (q.st == S_DEV) begin
                            if (q.sh[7:1] == DEV_ADDR && !q.sh[0]) begin
                                n.st = S_DEV_ACK;
                                n.oe = 1'b1;
                            end else begin
                                n.st = S_IDLE;
                            end
                        end else if (q.st == S_WADR) begin
                            n.page = q.sh[7:PAGE_W];
                            n.ptr  = q.sh[PAGE_W-1:0];
                            n.st   = S_WADR_ACK;
                            n.oe   = 1'b1;
                        end else if (!q.have && wp_i && q.page[HI_W-1]) begin
                            n.st = S_IDLE;
                        end else begin
                            we_d   = 1'b1;
                            n.ptr  = q.ptr + PTR_ONE;
                            n.have = 1'b1;
                            n.st   = S_DATA_ACK;
                            n.oe   = 1'b1;
                        end
                    end
                end
                S_DEV_ACK, S_WADR_ACK, S_DATA_ACK: begin
                    if (scl_fall_i) begin
                        n.oe   = 1'b0;
                        n.bitn = 4'd0;
                        n.st   = (q.st == S_DEV_ACK) ? S_WADR : S_DATA;
                    end
                end
                default: n.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= S_IDLE;
        end else begin
            q <= n;
        end
    end

    assign ack_oe_o    = q.oe;
    assign txn_start_o = txn_d;
    assign buf_we_o    = we_d;
    assign buf_idx_o   = q.ptr;
    assign buf_data_o  = q.sh;
    assign commit_o    = commit_d;
    assign page_o      = q.page;

    p_silent_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        busy_i |-> !q.oe)
        else $error("acknowledge driven while program cycle runs");

    p_ack_after_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.oe) |-> $past(scl_fall_i))
        else $error("acknowledge raised outside a clock-low phase");

endmodule

// File: rtl/ee_page_prog.sv
module ee_page_prog #(
    parameter int ADDR_W       = 8,
    parameter int PAGE_W       = 4,
    parameter int WRITE_CYCLES = 64
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     clear_i,
    input  logic                     buf_we_i,
    input  logic [PAGE_W-1:0]        buf_idx_i,
    input  logic [7:0]               buf_data_i,
    input  logic                     commit_i,
    input  logic [ADDR_W-PAGE_W-1:0] page_i,
    input  logic [ADDR_W-1:0]        peek_addr_i,
    output logic [7:0]               peek_data_o,
    output logic                     busy_o
);

    localparam int PAGE_BYTES = 1 << PAGE_W;
    localparam int DEPTH      = 1 << ADDR_W;
    localparam int HI_W       = ADDR_W - PAGE_W;
    localparam int CW         = $clog2(WRITE_CYCLES + 1);

    typedef struct packed {
        logic                  busy;
        logic [CW-1:0]         cnt;
        logic [PAGE_BYTES-1:0] valid;
        logic [HI_W-1:0]       page;
    } prg_s;

    prg_s q, n;
    logic prog_now;
    logic [7:0] pbuf_q [PAGE_BYTES];
    logic [7:0] mem_q  [DEPTH];

    assign prog_now = q.busy && (q.cnt == CW'(1));

    always_comb begin
        n = q;
        if (q.busy) begin
            n.cnt = q.cnt - CW'(1);
            if (prog_now) begin
                n.busy  = 1'b0;
                n.valid = '0;
            end
        end
        if (clear_i) n.valid = '0;
        if (buf_we_i) n.valid[buf_idx_i] = 1'b1;
        if (commit_i) begin
            n.busy = 1'b1;
            n.cnt  = CW'(WRITE_CYCLES);
            n.page = page_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < PAGE_BYTES; i++) pbuf_q[i] <= 8'h00;
        end else if (buf_we_i) begin
            pbuf_q[buf_idx_i] <= buf_data_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= 8'h00;
        end else if (prog_now) begin
            for (int i = 0; i < PAGE_BYTES; i++)
                if (q.valid[i]) mem_q[{q.page, i[PAGE_W-1:0]}] <= pbuf_q[i];
        end
    end

    assign peek_data_o = mem_q[peek_addr_i];
    assign busy_o      = q.busy;

    p_busy_from_commit_r5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.busy) |-> $past(commit_i))
        else $error("program cycle began without a commit");

    p_no_commit_busy_r6: assert property (@(posedge clk) disable iff (!rst_n)
        q.busy |-> !commit_i)
        else $error("commit requested during a running program cycle");

    p_commit_nonempty_r12: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |-> (q.valid != '0))
        else $error("commit with an empty page buffer");

endmodule

// File: rtl/eeprom_wr_target.sv
module eeprom_wr_target #(
    parameter logic [6:0] DEV_ADDR     = 7'h50,
    parameter int         ADDR_W       = 8,
    parameter int         PAGE_W       = 4,
    parameter int         WRITE_CYCLES = 64,
    parameter int         SYNC_STAGES  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    input  logic              wp_i,
    output logic              sda_oe_o,
    output logic              busy_o,
    input  logic [ADDR_W-1:0] peek_addr_i,
    output logic [7:0]        peek_data_o
);

    localparam int HI_W = ADDR_W - PAGE_W;

    logic sda_lvl, scl_rise, scl_fall, start_det, stop_det;
    logic txn_start, buf_we, commit;
    logic [PAGE_W-1:0] buf_idx;
    logic [7:0]        buf_data;
    logic [HI_W-1:0]   page;

    ee_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl_i),
        .sda_i      (sda_i),
        .sda_lvl_o  (sda_lvl),
        .scl_rise_o (scl_rise),
        .scl_fall_o (scl_fall),
        .start_o    (start_det),
        .stop_o     (stop_det)
    );

    ee_byte_fsm #(
        .DEV_ADDR (DEV_ADDR),
        .ADDR_W   (ADDR_W),
        .PAGE_W   (PAGE_W)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_rise_i  (scl_rise),
        .scl_fall_i  (scl_fall),
        .start_i     (start_det),
        .stop_i      (stop_det),
        .sda_lvl_i   (sda_lvl),
        .wp_i        (wp_i),
        .busy_i      (busy_o),
        .ack_oe_o    (sda_oe_o),
        .txn_start_o (txn_start),
        .buf_we_o    (buf_we),
        .buf_idx_o   (buf_idx),
        .buf_data_o  (buf_data),
        .commit_o    (commit),
        .page_o      (page)
    );

    ee_page_prog #(
        .ADDR_W       (ADDR_W),
        .PAGE_W       (PAGE_W),
        .WRITE_CYCLES (WRITE_CYCLES)
    ) u_prog (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (txn_start),
        .buf_we_i    (buf_we),
        .buf_idx_i   (buf_idx),
        .buf_data_i  (buf_data),
        .commit_i    (commit),
        .page_i      (page),
        .peek_addr_i (peek_addr_i),
        .peek_data_o (peek_data_o),
        .busy_o      (busy_o)
    );

endmodule

// File: tb/test_eeprom_wr_target.sv
module test_eeprom_wr_target;

    localparam int WC = 600;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl_m = 1'b1;
    logic       sda_m = 1'b1;
    logic       wp = 1'b0;
    logic [7:0] peek_addr = 8'h00;
    logic [7:0] peek_data;
    logic       sda_oe, busy, sda_line;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    logic [7:0] model [256];
    bit    exp_q [$];
    string tag_q [$];
    event  ack_ev;

    always #5 clk = ~clk;
    assign sda_line = sda_m & ~sda_oe;

    eeprom_wr_target #(.WRITE_CYCLES(WC)) i_eeprom_wr_target (
        .clk         (clk),
        .rst_n       (rst_n),
        .scl_i       (scl_m),
        .sda_i       (sda_line),
        .wp_i        (wp),
        .sda_oe_o    (sda_oe),
        .busy_o      (busy),
        .peek_addr_i (peek_addr),
        .peek_data_o (peek_data)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic qtr();
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        sda_m = 1'b1; qtr();
        scl_m = 1'b1; qtr();
        sda_m = 1'b0; qtr();
        scl_m = 1'b0; qtr();
    endtask

    task automatic bus_stop();
        sda_m = 1'b0; qtr();
        scl_m = 1'b1; qtr();
        sda_m = 1'b1;
    endtask

    task automatic send_byte(input logic [7:0] b, input bit exp_ack, input string tag);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; qtr();
            scl_m = 1'b1; qtr(); qtr();
            scl_m = 1'b0; qtr();
        end
        sda_m = 1'b1;
        exp_q.push_back(exp_ack);
        tag_q.push_back(tag);
        qtr();
        scl_m = 1'b1; qtr();
        -> ack_ev;
        qtr();
        scl_m = 1'b0; qtr();
    endtask

    // monitor: pops the expected acknowledge and compares with the line
    initial begin
        forever begin
            @(ack_ev);
            #1;
            begin
                bit    e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                chk((~sda_line) == e, t, int'(~sda_line), int'(e));
            end
        end
    end

    task automatic mem_chk(input logic [7:0] a, input string req);
        peek_addr = a;
        #1;
        chk(peek_data == model[a], req, int'(peek_data), int'(model[a]));
    endtask

    task automatic busy_len(input string req);
        int n = 0;
        int t = 0;
        while (!busy && t < 40) begin @(negedge clk); t++; end
        while (busy && n < WC + 100) begin @(negedge clk); n++; end
        chk(n == WC, req, n, WC);
    endtask

    task automatic quiet(input string req);
        bit seen = 1'b0;
        repeat (60) begin @(negedge clk); if (busy) seen = 1'b1; end
        chk(!seen, req, int'(seen), 0);
    endtask

    task automatic wr_txn(input logic [7:0] wa, input int cnt, input logic [7:0] base, input string tag);
        bus_start();
        send_byte(8'hA0, 1'b1, tag);
        send_byte(wa, 1'b1, tag);
        for (int k = 0; k < cnt; k++) begin
            logic [7:0] v;
            logic [3:0] lo;
            v  = base + 8'(k);
            lo = wa[3:0] + 4'(k);
            send_byte(v, 1'b1, tag);
            model[{wa[7:4], lo}] = v;
        end
        bus_stop();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 256; i++) model[i] = 8'h00;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);

        // R1 reset state
        chk(busy == 1'b0, "R1 busy", int'(busy), 0);
        chk(sda_oe == 1'b0, "R1 sda_oe", int'(sda_oe), 0);
        mem_chk(8'h00, "R1 mem");
        mem_chk(8'hFF, "R1 mem");

        // R2 wrong address and read direction are refused
        bus_start(); send_byte(8'hA4, 1'b0, "R2 other addr"); bus_stop();
        bus_start(); send_byte(8'hA1, 1'b0, "R2 read bit"); bus_stop();

        // R3 R4 R5 single byte write
        bus_start();
        send_byte(8'hA0, 1'b1, "R2 dev match");
        send_byte(8'h23, 1'b1, "R3 word addr");
        send_byte(8'hA5, 1'b1, "R3 data");
        peek_addr = 8'h23; #1;
        chk(peek_data == 8'h00, "R4 before stop", int'(peek_data), 0);
        bus_stop();
        model[8'h23] = 8'hA5;
        busy_len("R5 busy length");
        mem_chk(8'h23, "R4 after cycle");
        mem_chk(8'h24, "R4 neighbour");

        // R6 R7 R12 polling and ignored traffic while busy
        wr_txn(8'h05, 1, 8'h77, "R3 poll setup");
        bus_start();
        send_byte(8'hA0, 1'b0, "R6 poll busy");
        send_byte(8'h60, 1'b0, "R6 addr busy");
        send_byte(8'h11, 1'b0, "R6 data busy");
        bus_stop();
        chk(busy == 1'b1, "R6 still busy", int'(busy), 1);
        while (busy) @(negedge clk);
        mem_chk(8'h60, "R6 ignored write");
        mem_chk(8'h05, "R4 poll write");
        bus_start();
        send_byte(8'hA0, 1'b1, "R7 poll ready");
        send_byte(8'h70, 1'b1, "R3 word addr");
        bus_stop();
        quiet("R12 no data no cycle");

        // R8 wrap inside a page
        wr_txn(8'h3E, 3, 8'hC0, "R3 page");
        busy_len("R5 busy length page");
        mem_chk(8'h3E, "R8 first");
        mem_chk(8'h3F, "R8 second");
        mem_chk(8'h30, "R8 wrapped");
        mem_chk(8'h40, "R8 next page untouched");

        // R9 overflow overwrites
        wr_txn(8'h50, 18, 8'h01, "R3 overflow");
        busy_len("R5 busy length overflow");
        chk(model[8'h50] == 8'h11, "R9 model", int'(model[8'h50]), 8'h11);
        mem_chk(8'h50, "R9 offset0");
        mem_chk(8'h51, "R9 offset1");
        mem_chk(8'h52, "R9 offset2");
        mem_chk(8'h5F, "R9 offset15");

        // R10 protected upper half
        wp = 1'b1;
        bus_start();
        send_byte(8'hA0, 1'b1, "R10 dev");
        send_byte(8'h90, 1'b1, "R10 addr");
        send_byte(8'h99, 1'b0, "R10 data nack");
        bus_stop();
        quiet("R10 no cycle");
        mem_chk(8'h90, "R10 mem");

        // R11 lower half writable while protected
        wr_txn(8'h10, 1, 8'h3C, "R11 lower");
        busy_len("R11 busy");
        mem_chk(8'h10, "R11 mem");
        wp = 1'b0;

        repeat (10) @(negedge clk);
        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule